// File: doc/BRIEF.md
# Interrupt Source Lifecycle Tracker

This block tracks a small bank of wired interrupt sources, 16 by default, and runs one four-state lifecycle machine for each. A source is idle, waiting for service, in service, or in service with a further request waiting. Each source can be set to level-sensitive or edge-triggered mode, and the two modes follow different transition graphs. From the waiting sources that are enabled and pass the priority mask, the block picks the most urgent one. It shows that source's ID and drives a single request line toward the processor.

The processor claims the chosen source with a one-cycle acknowledge strobe and reads the claimed ID back on the next cycle. When its handler is done, it sends an end-of-service strobe that names the ID. All control pins are plain single-cycle strobes or static levels. No data stream crosses the edge of the block, so there is no valid/ready pairing and no back-pressure: every strobe takes effect on the clock edge where it is sampled high.

Top module: `intr_life_tracker`

## Requirements
- R1: After reset, every source is idle, the request line is low, the top ID is 1023 and the acknowledge response is 1023. Source i reports its state in bits [2i+1:2i] of the state bus, encoded 0 = idle, 1 = waiting, 2 = in service, 3 = in service with a request waiting.
- R2: An idle source becomes waiting on the clock edge where its assertion is seen. In level mode, assertion means the line is high. In edge mode, it means a 0-to-1 change between two samples. A level source that is still waiting when its line falls returns to idle. An edge source stays waiting after its line falls.
- R3: A source qualifies when it is waiting, enabled, and its 4-bit priority value (bits [4i+3:4i] of the priority bus) is strictly below the mask. The top ID is the qualifying source with the lowest priority value, with ties going to the lower ID. It is 1023 when nothing qualifies. The request line is high exactly when some source qualifies.
- R4: An acknowledge returns the top ID on the response output one cycle later and takes that source out of the waiting state, so the request line drops unless another source qualifies. If nothing qualifies, the acknowledge returns 1023 and changes no state.
- R5: Level mode: an acknowledge moves a waiting source with its line still high to in service with a request waiting. A falling line then moves it to in service. A high line while in service moves it back to in service with a request waiting.
- R6: Edge mode: an acknowledge moves a waiting source to in service. A rising edge while in service moves it to in service with a request waiting. Further edges in that state are merged into the one waiting request.
- R7: Edge mode: an end-of-service that names a source in service with a request waiting returns it to waiting, and the request line rises again.
- R8: An end-of-service that names a source in service returns it to idle in either mode. In level mode, an end-of-service that names a source in service with a request waiting returns it to waiting while the line is high.
- R9: An end-of-service that names an ID whose source is not in service, or that names no source at all, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_line | input | NUM_SRC | Raw interrupt lines, one per source |
| src_enable | input | NUM_SRC | Per-source enable |
| src_edge | input | NUM_SRC | Per-source mode: 1 = edge-triggered, 0 = level-sensitive |
| src_prio | input | NUM_SRC*PRIO_W | Per-source priority, lower value is more urgent |
| prio_mask | input | PRIO_W | Only priorities strictly below this value may request |
| ack_req | input | 1 | One-cycle acknowledge strobe |
| ack_id | output | ID_W | ID claimed by the most recent acknowledge (1023 if spurious) |
| eos_req | input | 1 | One-cycle end-of-service strobe |
| eos_id | input | ID_W | ID named by the end-of-service strobe |
| irq | output | 1 | Request line to the processor |
| top_id | output | ID_W | Current most urgent qualifying waiting source, or 1023 |
| src_state | output | 2*NUM_SRC | Packed per-source lifecycle states |

## Verification
The hardest state to reach from the ports is an edge source in service with a request waiting that has absorbed several extra edges. From outside, that source looks the same as one that saw a single edge. The stimulus acknowledges the source, pulses its line twice, and then sends end-of-service followed by a second acknowledge. A merged request must land in plain in service after that second claim, not back in service with a request waiting. The level path is reached by holding a line high across the acknowledge and then dropping and re-raising it before end-of-service.

// File: rtl/intr_life_pkg.sv
package intr_life_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT      = 2'd1,
    ST_SERV      = 2'd2,
    ST_SERV_WAIT = 2'd3
  } src_state_e;
endpackage

// File: rtl/intr_src_fsm.sv
module intr_src_fsm
  import intr_life_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_i,
  input  logic       edge_mode_i,
  input  logic       ack_hit_i,
  input  logic       eos_hit_i,
  output logic [1:0] state_o
);
  src_state_e st_q, st_d;
  logic       line_q;
  logic       rise;
  logic       assert_ev;

  // sample the raw line for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_i;
  end

  assign rise      = line_i & ~line_q;
  assign assert_ev = edge_mode_i ? rise : line_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (assert_ev) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (ack_hit_i) begin
          if (edge_mode_i) st_d = rise   ? ST_SERV_WAIT : ST_SERV;
          else             st_d = line_i ? ST_SERV_WAIT : ST_SERV;
        end else if (!edge_mode_i && !line_i) begin
          st_d = ST_IDLE;
        end
      end
      ST_SERV: begin
        if (eos_hit_i)      st_d = (edge_mode_i && rise) ? ST_WAIT : ST_IDLE;
        else if (assert_ev) st_d = ST_SERV_WAIT;
      end
      ST_SERV_WAIT: begin
        if (eos_hit_i)                     st_d = (edge_mode_i || line_i) ? ST_WAIT : ST_IDLE;
        else if (!edge_mode_i && !line_i)  st_d = ST_SERV;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state_o = st_q;

  // R4
  wait_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !ack_hit_i) |=> (st_q == ST_WAIT || st_q == ST_IDLE));

  // R5
  lvl_drop_to_serv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SERV_WAIT && !edge_mode_i && !line_i && !eos_hit_i) |=> st_q == ST_SERV);

  // R6
  edge_ack_serv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && ack_hit_i && edge_mode_i && !rise) |=> st_q == ST_SERV);

  // R6
  edge_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SERV_WAIT && edge_mode_i && !eos_hit_i) |=> st_q == ST_SERV_WAIT);

  // R7
  edge_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SERV_WAIT && edge_mode_i && eos_hit_i) |=> st_q == ST_WAIT);

  // R8
  eos_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SERV && eos_hit_i && !edge_mode_i) |=> st_q == ST_IDLE);

  // R9
  eos_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && eos_hit_i && !assert_ev) |=> st_q == ST_IDLE);
endmodule

// File: rtl/intr_pick.sv
module intr_pick #(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 4,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]        wait_vec,
  input  logic [NUM_SRC-1:0]        enable_vec,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_vec,
  input  logic [PRIO_W-1:0]         mask,
  output logic                      any_o,
  output logic [IDX_W-1:0]          idx_o
);
  logic [NUM_SRC-1:0] qual;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_qual
    assign qual[g] = wait_vec[g] & enable_vec[g] & (prio_vec[g*PRIO_W +: PRIO_W] < mask);
  end

  // linear scan, ascending ID; strict compare keeps the lower ID on a tie
  always_comb begin
    logic [PRIO_W-1:0] best_p;
    any_o  = 1'b0;
    idx_o  = '0;
    best_p = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (qual[i] && (!any_o || prio_vec[i*PRIO_W +: PRIO_W] < best_p)) begin
        any_o  = 1'b1;
        idx_o  = IDX_W'(i);
        best_p = prio_vec[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/intr_life_tracker.sv
module intr_life_tracker
  import intr_life_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 4,
  parameter int ID_W    = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        src_line,
  input  logic [NUM_SRC-1:0]        src_enable,
  input  logic [NUM_SRC-1:0]        src_edge,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
  input  logic [PRIO_W-1:0]         prio_mask,
  input  logic                      ack_req,
  output logic [ID_W-1:0]           ack_id,
  input  logic                      eos_req,
  input  logic [ID_W-1:0]           eos_id,
  output logic                      irq,
  output logic [ID_W-1:0]           top_id,
  output logic [2*NUM_SRC-1:0]      src_state
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [ID_W-1:0] SPURIOUS_ID = ID_W'(1023);

  logic [1:0]         st [NUM_SRC];
  logic [NUM_SRC-1:0] wait_vec;
  logic               any_q;
  logic [IDX_W-1:0]   win_idx;
  logic [ID_W-1:0]    ack_id_q;

  intr_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_pick (
    .wait_vec   (wait_vec),
    .enable_vec (src_enable),
    .prio_vec   (src_prio),
    .mask       (prio_mask),
    .any_o      (any_q),
    .idx_o      (win_idx)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic ack_hit, eos_hit;
    assign ack_hit = ack_req & any_q & (win_idx == IDX_W'(g));
    assign eos_hit = eos_req & (eos_id == ID_W'(g));

    intr_src_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_i      (src_line[g]),
      .edge_mode_i (src_edge[g]),
      .ack_hit_i   (ack_hit),
      .eos_hit_i   (eos_hit),
      .state_o     (st[g])
    );

    assign wait_vec[g]        = (st[g] == ST_WAIT);
    assign src_state[2*g +: 2] = st[g];
  end

  assign irq    = any_q;
  assign top_id = any_q ? ID_W'(win_idx) : SPURIOUS_ID;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ack_id_q <= SPURIOUS_ID;
    else if (ack_req) ack_id_q <= top_id;
  end

  assign ack_id = ack_id_q;

  // R3
  irq_has_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st[win_idx] == ST_WAIT && src_enable[win_idx]));

  // R4
  spurious_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !irq) |=> ack_id == SPURIOUS_ID);

  // R4
  ack_leaves_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && irq) |=> st[$past(win_idx)] != ST_WAIT);
endmodule

// File: tb/intr_life_tracker_test.sv
module intr_life_tracker_test;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_line = '0;
  logic [N-1:0]  src_enable = '1;
  logic [N-1:0]  src_edge = '0;
  logic [N*4-1:0] src_prio = {N{4'h8}};
  logic [3:0]    prio_mask = 4'hF;
  logic          ack_req = 1'b0;
  logic [9:0]    ack_id;
  logic          eos_req = 1'b0;
  logic [9:0]    eos_id = '0;
  logic          irq;
  logic [9:0]    top_id;
  logic [2*N-1:0] src_state;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  intr_life_tracker uut (
    .clk(clk), .rst_n(rst_n), .src_line(src_line), .src_enable(src_enable),
    .src_edge(src_edge), .src_prio(src_prio), .prio_mask(prio_mask),
    .ack_req(ack_req), .ack_id(ack_id), .eos_req(eos_req), .eos_id(eos_id),
    .irq(irq), .top_id(top_id), .src_state(src_state)
  );

  typedef struct packed {
    logic [15:0] lines;
    logic [15:0] en;
    logic [63:0] prio;
    logic [3:0]  mask;
    logic [9:0]  exp_id;
    logic        exp_irq;
  } vec_t;

  // R3 arbitration vectors (level sources, lines held)
  localparam vec_t VECS [6] = '{
    '{16'h0000, 16'hFFFF, 64'h8888_8888_8888_8888, 4'hF, 10'd1023, 1'b0},
    '{16'h0011, 16'hFFFF, 64'h8888_8888_8883_8885, 4'hF, 10'd4,    1'b1},
    '{16'h0011, 16'hFFFF, 64'h8888_8888_8888_8888, 4'hF, 10'd0,    1'b1},
    '{16'h0011, 16'hFFFF, 64'h8888_8888_8888_8888, 4'h8, 10'd1023, 1'b0},
    '{16'h0011, 16'hFFFE, 64'h8888_8888_8888_8888, 4'hF, 10'd4,    1'b1},
    '{16'h8000, 16'hFFFF, 64'h0888_8888_8888_8888, 4'h1, 10'd15,   1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [1:0] st_of(input int i);
    return src_state[2*i +: 2];
  endfunction

  task automatic do_ack();
    ack_req = 1'b1; step(); ack_req = 1'b0;
  endtask

  task automatic do_eos(input int id);
    eos_req = 1'b1; eos_id = 10'(id); step(); eos_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 state", src_state, 0);
    chk("R1 irq", irq, 0);
    chk("R1 top_id", top_id, 1023);
    chk("R1 ack_id", ack_id, 1023);
    rst_n = 1'b1;
    step();

    for (int v = 0; v < 6; v++) begin
      src_line = VECS[v].lines; src_enable = VECS[v].en;
      src_prio = VECS[v].prio;  prio_mask  = VECS[v].mask;
      step(); step();
      chk($sformatf("R3 vec%0d top_id", v), top_id, VECS[v].exp_id);
      chk($sformatf("R3 vec%0d irq", v), irq, VECS[v].exp_irq);
    end
    src_line = '0; src_enable = '1; src_prio = {N{4'h8}}; prio_mask = 4'hF;
    step(); step();
    chk("R2 level drop while waiting", src_state, 0);

    // level lifecycle on source 2
    src_line = 16'h0004; step();
    chk("R2 level waiting", st_of(2), 1);
    chk("R3 irq", irq, 1);
    do_ack();
    chk("R4 ack id", ack_id, 2);
    chk("R4 irq dropped", irq, 0);
    chk("R5 ack line high", st_of(2), 3);
    src_line = '0; step();
    chk("R5 line fall", st_of(2), 2);
    src_line = 16'h0004; step();
    chk("R5 line rise in service", st_of(2), 3);
    do_eos(2);
    chk("R8 level eos serv_wait", st_of(2), 1);
    do_ack();
    src_line = '0; step();
    chk("R5 back to service", st_of(2), 2);
    do_eos(2);
    chk("R8 level eos serv", st_of(2), 0);

    // edge lifecycle on source 5
    src_edge = 16'h0020;
    src_line = 16'h0020; step();
    chk("R2 edge waiting", st_of(5), 1);
    src_line = '0; step();
    chk("R2 edge holds after fall", st_of(5), 1);
    do_ack();
    chk("R4 ack id edge", ack_id, 5);
    chk("R6 edge ack", st_of(5), 2);
    src_line = 16'h0020; step(); src_line = '0; step();
    chk("R6 edge rearm", st_of(5), 3);
    src_line = 16'h0020; step(); src_line = '0; step();
    chk("R6 merged edge", st_of(5), 3);
    do_eos(5);
    chk("R7 edge eos to waiting", st_of(5), 1);
    chk("R7 irq again", irq, 1);
    do_ack();
    chk("R6 merged single request", st_of(5), 2);
    do_eos(5);
    chk("R8 edge eos serv", st_of(5), 0);
    src_edge = '0;

    // R9 ignored end-of-service
    do_eos(7);
    chk("R9 eos idle source", st_of(7), 0);
    src_line = 16'h0200; step();
    do_eos(9);
    chk("R9 eos waiting source", st_of(9), 1);
    do_eos(1000);
    chk("R9 eos no source", src_state, 32'h0004_0000);

    // R4 spurious acknowledge: source waits but is masked off
    prio_mask = 4'h0; step();
    chk("R3 masked irq", irq, 0);
    do_ack();
    chk("R4 spurious id", ack_id, 1023);
    chk("R4 spurious no change", st_of(9), 1);
    prio_mask = 4'hF; src_line = '0; step();
    chk("R2 level idle again", src_state, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule